// File: doc/BRIEF.md
# Oscillator Rate Trimmer for a Real-Time Clock

This block sits between a 32,768 Hz oscillator tick and the rest of a timekeeping chain. It turns the tick stream into a one-cycle pulse per second. A signed five-bit trim code corrects for a crystal that runs fast or slow. The code is taken at the start of each calibration window. For the first part of that window, every oscillator tick moves the second prescaler by two counts (speed up) or by none (slow down), until the window's budget of corrections is used. After that the prescaler moves one count per tick. Each speed-up step is worth 512 counts per 64-minute window, about +4.07 ppm. Each slow-down step is worth 256 counts, about −2.03 ppm. The full range is therefore about +5.5 or −2.75 minutes per month. As an example, a crystal measured 20 ppm fast takes ten slow-down steps: magnitude 10 with the direction bit clear.

For measuring the crystal, a test enable freezes timekeeping. While it is set, the block drives a square wave taken from the raw, uncorrected ticks. It toggles every `TEST_HALF` ticks, which gives 512 Hz from a nominal oscillator. The surrounding logic places this wave on data bit 0 while the seconds location is being read. Timekeeping continues from the held count once the enable is cleared.

Top module: `rtc_trim`

## Requirements
- R1: While reset is asserted and right after it is released, `sec_tick` and `test_sq` are 0.
- R2: With a trim magnitude of 0, consecutive `sec_tick` pulses are exactly `DIV` oscillator ticks apart.
- R3: With `cal_fast`=1 and magnitude m, the first second of each window lasts `DIV` − m·`STEP_UP` ticks. The other seconds of that window last `DIV` ticks. This holds while m·`STEP_UP` ≤ `DIV`/2.
- R4: With `cal_fast`=0 and magnitude m, the first second of each window lasts `DIV` + m·`STEP_DN` ticks. The other seconds of that window last `DIV` ticks.
- R5: The trim code is sampled only at the first oscillator tick of a window. A change made during a window takes effect in the next window.
- R6: A window is `WIN_SEC` seconds long. The correction is applied again in every window.
- R7: While `test_en`=1, `test_sq` toggles once every `TEST_HALF` oscillator ticks, starting from 0 at enable. While `test_en`=0, `test_sq` is 0.
- R8: While `test_en`=1, no `sec_tick` is produced and the prescaler holds. After `test_en` clears, counting resumes from the held value.
- R9: `sec_tick` lasts one clock cycle and follows an oscillator tick. The prescaler changes only on oscillator ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| cal_mag | input | MAG_W | Trim magnitude, 0 to 31 |
| cal_fast | input | 1 | Trim direction: 1 speeds up, 0 slows down |
| test_en | input | 1 | Frequency test enable |
| sec_tick | output | 1 | One-cycle pulse per corrected second |
| test_sq | output | 1 | Test square wave taken from the raw ticks |

## Verification
The assertions assume that `osc_tick` is a single-cycle pulse with idle cycles between pulses. They also assume that `test_en` and the trim code change only in clock-synchronous fashion. The bench drives one tick every four clock cycles and changes inputs just after a clock edge, so it keeps within these assumptions. Fast trim magnitudes are kept low enough that the first corrected second ends after the correction budget is used up (R3). This keeps every expected interval an exact tick count.

// File: rtl/rtc_trim.sv
module rtc_trim #(
  parameter int DIV       = 32768,
  parameter int WIN_SEC   = 3840,
  parameter int STEP_UP   = 512,
  parameter int STEP_DN   = 256,
  parameter int MAG_W     = 5,
  parameter int TEST_HALF = (DIV >= 1024) ? DIV / 1024 : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_fast,
  input  logic             test_en,
  output logic             sec_tick,
  output logic             test_sq
);
  localparam int CW   = $clog2(DIV) + 1;
  localparam int WW   = (WIN_SEC > 1) ? $clog2(WIN_SEC) : 1;
  localparam int STMX = (STEP_UP > STEP_DN) ? STEP_UP : STEP_DN;
  localparam int PW   = $clog2(((1 << MAG_W) - 1) * STMX + 1);
  localparam int TW   = $clog2(TEST_HALF) + 1;

  logic [CW-1:0] cnt;
  logic [WW-1:0] win;
  logic [PW-1:0] pend;
  logic          dir_fast, load_q, sec_q;
  logic [TW-1:0] th;
  logic          tgl, tsq_q;

  logic          run;
  logic [1:0]    inc;
  logic [CW-1:0] sum;
  logic          wrap;
  logic [PW-1:0] pend_init;

  assign run       = osc_tick & ~test_en;
  assign inc       = load_q ? 2'd1 : (pend != '0) ? (dir_fast ? 2'd2 : 2'd0) : 2'd1;
  assign sum       = cnt + CW'(inc);
  assign wrap      = sum >= CW'(DIV);
  assign pend_init = PW'(int'(cal_mag) * (cal_fast ? STEP_UP : STEP_DN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      win      <= '0;
      pend     <= '0;
      dir_fast <= 1'b0;
      load_q   <= 1'b1;
      sec_q    <= 1'b0;
    end else if (run) begin
      cnt   <= wrap ? sum - CW'(DIV) : sum;
      sec_q <= wrap;
      if (load_q) begin
        pend     <= pend_init;
        dir_fast <= cal_fast;
        load_q   <= 1'b0;
      end else if (pend != '0) begin
        pend <= pend - 1'b1;
      end
      if (wrap) begin
        if (win == WW'(WIN_SEC - 1)) begin
          win    <= '0;
          load_q <= 1'b1;
        end else begin
          win <= win + 1'b1;
        end
      end
    end else begin
      sec_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !test_en) begin
      th  <= '0;
      tgl <= 1'b0;
    end else if (osc_tick) begin
      if (th == TW'(TEST_HALF - 1)) begin
        th  <= '0;
        tgl <= ~tgl;
      end else begin
        th <= th + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tsq_q <= 1'b0;
    else        tsq_q <= test_en & tgl;
  end

  assign sec_tick = sec_q;
  assign test_sq  = tsq_q;
endmodule

module rtc_trim_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          osc_tick,
  input logic          test_en,
  input logic          sec_tick,
  input logic          test_sq,
  input logic [CW-1:0] cnt
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
  a_r9_after_osc: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(osc_tick));
  a_r9_cnt_still: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(osc_tick) |-> $stable(cnt));
  a_r8_no_tick_in_test: assert property (@(posedge clk) disable iff (!rst_n)
    $past(test_en) |-> !sec_tick);
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(test_en) |-> !test_sq);
endmodule

bind rtc_trim rtc_trim_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .test_en(test_en),
  .sec_tick(sec_tick), .test_sq(test_sq), .cnt(cnt)
);

// File: tb/rtc_trim_tb.sv
module rtc_trim_tb;
  localparam int CLK_P = 10;
  localparam int DIV = 64, WIN = 4, SU = 2, SD = 1, TH = 2;

  logic clk = 0, rst_n = 0, osc = 0, fast = 0, ten = 0;
  logic [4:0] mag = '0;
  logic sec, tsq;
  int checks = 0, fails = 0;
  int tk = 0, last = 0;
  int q[$];
  logic prev_sec = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_trim #(.DIV(DIV), .WIN_SEC(WIN), .STEP_UP(SU), .STEP_DN(SD), .MAG_W(5), .TEST_HALF(TH)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc), .cal_mag(mag), .cal_fast(fast),
    .test_en(ten), .sec_tick(sec), .test_sq(tsq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected second lengths
  always @(negedge clk) begin
    if (!rst_n) begin
      tk = 0; last = 0; prev_sec = 0;
    end else begin
      if (osc) tk++;
      if (sec && prev_sec) chk(0, "R9 double pulse", 1, 0);
      if (sec) begin
        if (q.size() == 0) chk(0, "R8 unexpected sec_tick", tk - last, 0);
        else begin
          int e;
          e = q.pop_front();
          chk(tk - last == e, "R2-R6 second length", tk - last, e);
        end
        last = tk;
      end
      prev_sec = sec;
    end
  end

  task automatic tick();
    @(posedge clk); #2 osc = 1;
    @(posedge clk); #2 osc = 0;
    repeat (2) @(posedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #2 rst_n = 0; ten = 0; osc = 0;
    q.delete();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
  endtask

  task automatic push_win(input int m, input bit f);
    q.push_back(f ? DIV - m*SU : DIV + m*SD);
    for (int i = 1; i < WIN; i++) q.push_back(DIV);
  endtask

  function automatic int win_len(input int m, input bit f);
    return (f ? DIV - m*SU : DIV + m*SD) + (WIN-1)*DIV;
  endfunction

  task automatic drain(input string req);
    repeat (3) @(posedge clk);
    #1 chk(q.size() == 0, req, q.size(), 0);
  endtask

  task automatic run_code(input int m, input bit f, input int nwin, input string req);
    do_reset();
    mag = 5'(m); fast = f;
    for (int w = 0; w < nwin; w++) push_win(m, f);
    for (int i = 0; i < nwin*win_len(m, f); i++) tick();
    drain(req);
  endtask

  initial begin
    #(CLK_P*200000);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    ten = 1; osc = 1;
    repeat (3) @(negedge clk);
    chk(sec == 0, "R1 sec_tick in reset", sec, 0);
    chk(tsq == 0, "R1 test_sq in reset", tsq, 0);
    #2 rst_n = 1; osc = 0; ten = 0;
    @(negedge clk);
    chk(sec == 0 && tsq == 0, "R1 after release", {sec, tsq}, 0);

    run_code(0, 0, 2, "R2 all seconds queued seen");
    run_code(0, 1, 1, "R2 fast zero");
    run_code(5, 1, 2, "R3 and R6 fast five");
    run_code(15, 1, 1, "R3 fast fifteen");
    run_code(10, 0, 2, "R4 and R6 slow ten");
    run_code(31, 0, 1, "R4 slow full scale");

    // R5: mid-window change applies next window
    do_reset();
    mag = 5'd5; fast = 1;
    push_win(5, 1); push_win(10, 0);
    for (int i = 0; i < (DIV - 5*SU) + DIV; i++) tick();
    mag = 5'd10; fast = 0;
    for (int i = 0; i < win_len(5, 1) - (DIV - 5*SU) - DIV + win_len(10, 0); i++) tick();
    drain("R5 code sampled at window start");

    // R7/R8: test mode
    do_reset();
    mag = '0; fast = 0;
    q.push_back(DIV + 8);
    for (int i = 0; i < 20; i++) tick();
    @(posedge clk); #2 ten = 1;
    for (int n = 1; n <= 8; n++) begin
      tick();
      #1 chk(tsq == 1'((n / TH) % 2), "R7 test square", tsq, (n / TH) % 2);
    end
    @(posedge clk); #2 ten = 0;
    repeat (2) @(posedge clk);
    #1 chk(tsq == 0, "R7 quiet after clear", tsq, 0);
    for (int i = 0; i < DIV - 20; i++) tick();
    drain("R8 resume from held count");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule